// File: doc/BRIEF.md
# Write-zero-clear interrupt cause controller

This block holds a 32-bit interrupt cause register and a matching 32-bit mask register for a serial-link host interface. Most cause bits are sticky event flags: a one-cycle hardware pulse sets the bit, and the bit stays set until software writes a zero to that position. Writing a one leaves a sticky bit unchanged, so software clears exactly the events it has handled by writing the complement of what it read. Four cause bits, 24 to 27, track legacy INTA to INTD. Assert and deassert messages received from the link set and clear these bits, and software writes have no effect on them.

Each cause bit has a mask bit. A mask bit of 1 lets its cause bit drive the single level interrupt output. The mask never stops a cause bit from latching. Software reads and writes both registers over a simple register bus. The bus has one address bit, a write strobe and 32-bit write data. Reads take no wait states.

Top module: `wz_irq_cause_ctrl`

## Requirements
- R1: After reset the cause register and the mask register read as all zeros and `irq_o` is low.
- R2: A sticky cause bit (positions 0, 1, 3, 4, 6, 7, 8 to 12, 14 to 23 and 28) sets in the cycle after a pulse on its `evt_i` bit and stays set while no clearing write reaches it.
- R3: A write to the cause register (`reg_addr_i` = 0) clears every sticky bit whose write-data bit is 0 and leaves every sticky bit whose write-data bit is 1 unchanged.
- R4: When an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit is set afterwards.
- R5: Cause bit 24+i (i = 0..3) sets on `lvl_set_i[i]` and clears on `lvl_clr_i[i]`. Cause-register writes and `evt_i` pulses at positions 24 to 27 do not change these bits.
- R6: When `lvl_set_i[i]` and `lvl_clr_i[i]` are both high in the same cycle, cause bit 24+i is set afterwards.
- R7: A write with `reg_addr_i` = 1 loads the mask register from `reg_wdata_i`, and the new value reads back from the next cycle on.
- R8: The mask does not affect latching: a cause bit with its mask bit at 0 still sets on its event and reads back as 1.
- R9: `irq_o` is registered. In each cycle it equals the OR over all bits of (cause AND mask) as those registers stood in the previous cycle.
- R10: Positions 2, 5, 13, 29, 30 and 31 read as 0 in both registers. Events and writes at these positions are ignored, and these positions never raise `irq_o`.
- R11: `reg_rdata_o` shows the register selected by `reg_addr_i` in the same cycle (0 = cause, 1 = mask), with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | One-cycle event pulses, one per sticky cause bit |
| lvl_set_i | input | 4 | Assert-message pulses for INTA..INTD |
| lvl_clr_i | input | 4 | Deassert-message pulses for INTA..INTD |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 cause, 1 mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A walking single-bit event pulse exercises every position once. This separates sticky, level and unused positions and catches a bit mapped to the wrong place. Cause writes with all ones, a half pattern and all zeros tell write-one-keep apart from write-zero-clear. Same-cycle collisions of an event with a clear, and of an assert with a deassert, test the priority rules. The mask is run at zero, at all ones and at a subset to show that masking gates only `irq_o`. A long run of sparse random events, messages and writes is then compared cycle by cycle against a behavioural model.

// File: rtl/wz_irq_pkg.sv
package wz_irq_pkg;

   localparam int MAX_W = 64;

   localparam logic REG_CAUSE = 1'b0;
   localparam logic REG_MASK  = 1'b1;

   typedef enum logic [1:0] {
      BIT_NONE   = 2'd0,
      BIT_STICKY = 2'd1,
      BIT_LEVEL  = 2'd2
   } bit_kind_e;

   // Classify one cause position; level window takes precedence.
   function automatic bit_kind_e kind_of(input int idx,
                                         input logic [MAX_W-1:0] smap,
                                         input int lsb,
                                         input int n);
      if (idx >= lsb && idx < lsb + n) return BIT_LEVEL;
      if (smap[idx]) return BIT_STICKY;
      return BIT_NONE;
   endfunction

   function automatic logic [MAX_W-1:0] window_map(input int lsb, input int n);
      logic [MAX_W-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_W; i++)
         if (i >= lsb && i < lsb + n) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/wz_sticky_cell.sv
module wz_sticky_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic q_o
);
   // event has priority over a clearing write
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (evt_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/wz_level_cell.sv
module wz_level_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // assert message has priority over deassert
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/wz_irq_reduce.sv
module wz_irq_reduce #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cause_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              irq_o
);
   logic hit;
   assign hit = |(cause_i & mask_i);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= hit;
   end
endmodule

// File: rtl/wz_irq_cause_ctrl.sv
module wz_irq_cause_ctrl
   import wz_irq_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                LVL_LSB    = 24,
   parameter int                LVL_N      = 4,
   parameter logic [DATA_W-1:0] STICKY_MAP = 32'h10FF_DFDB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [LVL_N-1:0]  lvl_set_i,
   input  logic [LVL_N-1:0]  lvl_clr_i,
   input  logic              reg_wr_i,
   input  logic              reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   localparam logic [MAX_W-1:0]  STICKY_EXT = MAX_W'(STICKY_MAP);
   localparam logic [DATA_W-1:0] LVL_MAP    = DATA_W'(window_map(LVL_LSB, LVL_N));
   localparam logic [DATA_W-1:0] IMPL_MAP   = STICKY_MAP | LVL_MAP;

   // elaboration-time parameter checks
   if (DATA_W < 1 || DATA_W > MAX_W) begin : g_bad_width
      $error("DATA_W out of range");
   end
   if (LVL_N < 1 || LVL_LSB < 0 || LVL_LSB + LVL_N > DATA_W) begin : g_bad_window
      $error("level window does not fit in DATA_W");
   end
   if ((STICKY_MAP & LVL_MAP) != '0) begin : g_bad_overlap
      $error("sticky map overlaps level window");
   end

   logic              cause_wr;
   logic              mask_wr;
   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] mask_q;

   assign cause_wr = reg_wr_i && (reg_addr_i == REG_CAUSE);
   assign mask_wr  = reg_wr_i && (reg_addr_i == REG_MASK);

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      localparam bit_kind_e KIND = kind_of(g, STICKY_EXT, LVL_LSB, LVL_N);

      if (KIND == BIT_STICKY) begin : g_sticky
         wz_sticky_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i[g]),
            .clr_i (cause_wr && !reg_wdata_i[g]),
            .q_o   (cause_q[g])
         );
      end else if (KIND == BIT_LEVEL) begin : g_level
         wz_level_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lvl_set_i[g-LVL_LSB]),
            .clr_i (lvl_clr_i[g-LVL_LSB]),
            .q_o   (cause_q[g])
         );
      end else begin : g_none
         assign cause_q[g] = 1'b0;
      end

      if (KIND != BIT_NONE) begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n)       mask_q[g] <= 1'b0;
            else if (mask_wr) mask_q[g] <= reg_wdata_i[g];
         end
      end else begin : g_mask_none
         assign mask_q[g] = 1'b0;
      end
   end

   // inputs at positions that carry no sticky cell are dropped
   logic unused_evt;
   assign unused_evt = ^(evt_i & ~STICKY_MAP);

   assign reg_rdata_o = (reg_addr_i == REG_MASK) ? mask_q : cause_q;

   wz_irq_reduce #(.DATA_W(DATA_W)) u_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (cause_q),
      .mask_i  (mask_q),
      .irq_o   (irq_o)
   );

   logic unused_impl;
   assign unused_impl = ^IMPL_MAP;

endmodule

// File: rtl/wz_irq_cause_chk.sv
module wz_irq_cause_chk
   import wz_irq_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                LVL_LSB    = 24,
   parameter int                LVL_N      = 4,
   parameter logic [DATA_W-1:0] STICKY_MAP = 32'h10FF_DFDB
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] evt_i,
   input logic [LVL_N-1:0]  lvl_set_i,
   input logic [LVL_N-1:0]  lvl_clr_i,
   input logic              reg_wr_i,
   input logic              reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_o,
   input logic [DATA_W-1:0] cause_q,
   input logic [DATA_W-1:0] mask_q
);
   localparam logic [DATA_W-1:0] LVL_MAP  = DATA_W'(window_map(LVL_LSB, LVL_N));
   localparam logic [DATA_W-1:0] IMPL_MAP = STICKY_MAP | LVL_MAP;

   // R2
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & STICKY_MAP) != '0) |=>
         ((cause_q & $past(evt_i & STICKY_MAP)) == $past(evt_i & STICKY_MAP)));

   // R3
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_i && reg_addr_i == REG_CAUSE) |=>
         ((($past(cause_q) & ~cause_q) & STICKY_MAP) == '0));

   // R5
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_set_i == '0 && lvl_clr_i == '0) |=>
         ((cause_q & LVL_MAP) == ($past(cause_q) & LVL_MAP)));

   // R6
   level_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_set_i != '0) |=>
         ((cause_q[LVL_LSB +: LVL_N] & $past(lvl_set_i)) == $past(lvl_set_i)));

   // R9
   irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == |($past(cause_q & mask_q))));

   // R10
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q | mask_q | reg_rdata_o) & ~IMPL_MAP) == '0);

endmodule

bind wz_irq_cause_ctrl wz_irq_cause_chk #(
   .DATA_W     (DATA_W),
   .LVL_LSB    (LVL_LSB),
   .LVL_N      (LVL_N),
   .STICKY_MAP (STICKY_MAP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_i       (evt_i),
   .lvl_set_i   (lvl_set_i),
   .lvl_clr_i   (lvl_clr_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .cause_q     (cause_q),
   .mask_q      (mask_q)
);

// File: tb/wz_irq_cause_ctrl_tb.sv
module wz_irq_cause_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   localparam logic [31:0] T_STICKY = 32'h10FF_DFDB;
   localparam int          T_LVL    = 24;
   localparam logic [31:0] T_IMPL   = 32'h1FFF_DFDB;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] evt_i;
   logic [3:0]  lvl_set_i, lvl_clr_i;
   logic        reg_wr_i, reg_addr_i;
   logic [31:0] reg_wdata_i, reg_rdata_o;
   logic        irq_o;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    finished = 0;
   string cur_req  = "R1";

   logic [31:0] m_cause = '0, m_mask = '0;
   logic        m_irq   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wz_irq_cause_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .lvl_set_i(lvl_set_i), .lvl_clr_i(lvl_clr_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   // behavioural reference model, updated at each rising edge
   always @(posedge clk) begin
      logic [31:0] nc;
      if (!rst_n) begin
         m_cause = '0; m_mask = '0; m_irq = 1'b0;
      end else begin
         m_irq = ((m_cause & m_mask) != 0);
         nc = m_cause;
         for (int i = 0; i < 32; i++) begin
            if (T_STICKY[i]) begin
               if (evt_i[i]) nc[i] = 1'b1;
               else if (reg_wr_i && !reg_addr_i && !reg_wdata_i[i]) nc[i] = 1'b0;
            end else if (i >= T_LVL && i < T_LVL + 4) begin
               if (lvl_set_i[i-T_LVL]) nc[i] = 1'b1;
               else if (lvl_clr_i[i-T_LVL]) nc[i] = 1'b0;
            end else begin
               nc[i] = 1'b0;
            end
         end
         if (reg_wr_i && reg_addr_i) m_mask = reg_wdata_i & T_IMPL;
         m_cause = nc;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one cycle: compare at the falling edge, then drive the next stimulus
   task automatic tick(input logic [31:0] e, input logic [3:0] s, input logic [3:0] c,
                       input logic w, input logic a, input logic [31:0] d,
                       input string req);
      @(negedge clk);
      reg_wr_i = 1'b0;
      reg_addr_i = 1'b0; #1;
      check({cur_req, "/R11"}, "cause read", reg_rdata_o, m_cause);
      reg_addr_i = 1'b1; #1;
      check({cur_req, "/R11"}, "mask read", reg_rdata_o, m_mask);
      check({cur_req, "/R9"}, "irq", {31'd0, irq_o}, {31'd0, m_irq});
      cur_req = req;
      evt_i = e; lvl_set_i = s; lvl_clr_i = c;
      reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d;
   endtask

   task automatic idle(input string req);
      tick('0, '0, '0, 1'b0, 1'b0, '0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; evt_i = '0; lvl_set_i = '0; lvl_clr_i = '0;
      reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      idle("R1"); idle("R1");
      // R2 walking event across every position (unused ones per R10, level per R5)
      for (int i = 0; i < 32; i++) tick(32'd1 << i, '0, '0, 1'b0, 1'b0, '0, "R2");
      idle("R2");
      // R7 mask writes and read-back
      tick('0, '0, '0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R7");
      idle("R7");
      tick('0, '0, '0, 1'b1, 1'b1, 32'h0000_00F0, "R7");
      idle("R9"); idle("R9");
      // R3 write-one keeps, write-zero clears
      tick('0, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3");
      tick('0, '0, '0, 1'b1, 1'b0, 32'hFFFF_0000, "R3");
      idle("R9");
      tick('0, '0, '0, 1'b1, 1'b0, 32'h0000_0000, "R3");
      idle("R3");
      // R8 mask at zero does not block latching
      tick('0, '0, '0, 1'b1, 1'b1, 32'h0000_0000, "R8");
      tick(32'hFFFF_FFFF, '0, '0, 1'b0, 1'b0, '0, "R8");
      idle("R8"); idle("R8");
      tick('0, '0, '0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R9");
      idle("R9"); idle("R9");
      tick('0, '0, '0, 1'b1, 1'b0, 32'h0000_0000, "R3");
      idle("R9"); idle("R9");
      // R4 event beats a clearing write
      tick(32'h0000_0011, '0, '0, 1'b1, 1'b0, 32'h0000_0000, "R4");
      idle("R4");
      tick('0, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFEF, "R3");
      idle("R3");
      // R5 level bits driven only by messages
      tick('0, 4'b0101, '0, 1'b0, 1'b0, '0, "R5");
      tick('0, '0, '0, 1'b1, 1'b0, 32'h0000_0000, "R5");
      tick(32'h0F00_0000, '0, '0, 1'b0, 1'b0, '0, "R5");
      tick('0, '0, 4'b0001, 1'b0, 1'b0, '0, "R5");
      idle("R5");
      // R6 assert beats deassert
      tick('0, 4'b1010, 4'b1010, 1'b0, 1'b0, '0, "R6");
      idle("R6");
      tick('0, '0, 4'b1111, 1'b0, 1'b0, '0, "R6");
      idle("R6");
      // R10 unused positions
      tick('0, '0, '0, 1'b1, 1'b1, 32'hE000_2024, "R10");
      tick(32'hE000_2024, '0, '0, 1'b0, 1'b0, '0, "R10");
      tick('0, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R10");
      idle("R10"); idle("R10");
      // R9 mixed random traffic
      for (int k = 0; k < 150; k++) begin
         logic [31:0] e, d;
         logic [3:0]  s, c;
         logic        w, a;
         e = $urandom & $urandom & $urandom;
         s = 4'($urandom & $urandom);
         c = 4'($urandom & $urandom);
         w = ($urandom % 4) == 0;
         a = $urandom % 2;
         d = $urandom | $urandom;
         tick(e, s, c, w, a, d, "R9");
      end
      idle("R9"); idle("R9"); idle("R9");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule